// File: doc/BRIEF.md
# Linked-Buffer Receive DMA Engine

This block takes one incoming frame at a time as a byte stream and scatters it across a chain of buffers that software has prepared in memory. Each buffer is described by a four-word descriptor. The engine starts at the descriptor named by its current-pointer register and checks that software has handed over ownership. It then copies bytes into that descriptor's buffer until the buffer is full or the frame ends, and follows the next pointer when more bytes remain.

When a frame completes, the engine does four things. It writes the byte count of every descriptor it used and hands each one back to software. It flags the descriptor that closed the frame as the last and the descriptor that opened it as the first. It moves the current pointer past the chain it consumed and pulses a done cause. When it hits a missing or unowned descriptor, it pulses an error cause and discards the rest of the frame.

Descriptor layout (byte offsets from the descriptor address, 32-bit little-endian words):

| Offset | Word | Contents |
|---|---|---|
| +0 | size word | buffer capacity in [31:16], stored byte count in [15:0] |
| +4 | status word | ownership in bit 31, first-buffer flag in bit 17, last-buffer flag in bit 16 |
| +8 | link | address of the next descriptor |
| +12 | buffer | address of the buffer |

Top module: `rxdma_chain`

## Requirements
- R1: Each descriptor's buffer receives min(capacity, bytes still left in the frame), in arrival order, starting at its buffer address. Each data byte is written as one access with a single byte-lane enable, and byte lane k carries address offset k. On write-back the capacity in [31:16] is kept and [15:0] holds the stored count.
- R2: Every descriptor that receives data has its ownership bit 31 cleared on write-back. All other status bits are kept unless R3 sets them.
- R3: Only the descriptor that completes the frame gets bit 16 set. Only the descriptor the frame started in gets bit 17 set.
- R4: Follow-on descriptors are written back as soon as they are filled. The first descriptor is written back only after the frame ends, and its status word is the final memory write of the frame.
- R5: When mode_i is 0 (HDLC), the final descriptor's count is two larger than the bytes stored in it. Any other mode (for example 4, UART) adds nothing.
- R6: On success cur_ptr_o becomes the link word of the final descriptor, and done_o pulses for exactly one cycle. done_o and err_o are never high together.
- R7: If a descriptor is reached whose bit 31 is clear, err_o pulses and cur_ptr_o keeps its value. The first descriptor is not written back, and the rest of the frame up to and including its end-marked byte is consumed and dropped.
- R8: A frame that arrives while cur_ptr_o is zero pulses err_o, makes no memory write and is dropped.
- R9: A zero link word in a full buffer while bytes remain pulses err_o. A frame that ends exactly at the end of a buffer whose link is zero completes normally.
- R10: A frame stores at most 2048 bytes. The 2048th byte closes the frame as its last byte, and the bytes after it, up to the end marker, are dropped.
- R11: rx_ready_o is low while a memory request is outstanding. A request holds its address until mem_ack_i.
- R12: A cycle with ptr_wr_i high loads ptr_wdata_i into cur_ptr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| mode_i | input | 3 | channel mode; 0 selects HDLC count adjust |
| ptr_wr_i | input | 1 | load strobe for the current pointer |
| ptr_wdata_i | input | 32 | value loaded into the current pointer |
| cur_ptr_o | output | 32 | current receive descriptor pointer |
| rx_data_i | input | 8 | incoming frame byte |
| rx_valid_i | input | 1 | byte valid |
| rx_last_i | input | 1 | byte is the last of its frame |
| rx_ready_o | output | 1 | byte accepted when high with rx_valid_i |
| mem_req_o | output | 1 | memory request, held until acknowledged |
| mem_we_o | output | 1 | request is a write |
| mem_addr_o | output | 32 | byte address |
| mem_be_o | output | 4 | byte-lane enables |
| mem_wdata_o | output | 32 | write data |
| mem_ack_i | input | 1 | request completed; read data valid |
| mem_rdata_i | input | 32 | read data |
| done_o | output | 1 | frame stored (receive-done cause pulse) |
| err_o | output | 1 | frame failed (receive-error cause pulse) |

## Verification
The hardest situation to reach from the ports is the 2048-byte limit. It needs a frame longer than the limit that still lands in enough owned buffers, so that the cut is made by the byte count and not by running out of descriptors. The bench chains two 1024-byte buffers and streams 2100 bytes. It checks that the second buffer closes as last, that a sentinel just past it stays untouched, and that done_o comes while the tail is still being drained. A second hard case is the order of write-backs: the memory model records the address of every write, so the bench can confirm that the first descriptor's status word is the last write of a three-buffer frame.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_CHK, S_FILL, S_WBYTE, S_FIN, S_WB, S_NEXT, S_WBF, S_DROP
  } rx_state_e;

  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned FIRST_BIT = 17;
  localparam int unsigned LAST_BIT  = 16;
  localparam logic [2:0]  MODE_HDLC = 3'd0;
  localparam int unsigned CRC_PAD   = 2;
endpackage

// File: rtl/rxdma_desc_pack.sv
module rxdma_desc_pack
  import rxdma_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic [DW-1:0]    size_i,
  input  logic [DW-1:0]    stat_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_i,
  input  logic             first_i,
  input  logic             hdlc_i,
  output logic [DW-1:0]    size_o,
  output logic [DW-1:0]    stat_o
);
  logic [CNT_W-1:0] cnt_adj;

  always_comb begin
    cnt_adj = cnt_i + ((last_i && hdlc_i) ? CNT_W'(CRC_PAD) : '0);
    size_o  = {size_i[DW-1:CNT_W], cnt_adj};
    stat_o  = stat_i;
    stat_o[OWN_BIT] = 1'b0;
    if (last_i)  stat_o[LAST_BIT]  = 1'b1;
    if (first_i) stat_o[FIRST_BIT] = 1'b1;
  end
endmodule

// File: rtl/rxdma_byte_lane.sv
module rxdma_byte_lane #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]   addr_i,
  input  logic [7:0]      byte_i,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0]   wdata_o
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned LW = $clog2(NB);

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign be_o[k]          = (addr_i[LW-1:0] == LW'(k));
    assign wdata_o[8*k +: 8] = byte_i;
  end
endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
  import rxdma_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_FRAME = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          ptr_wr_i,
  input  logic [DW-1:0] ptr_wdata_i,
  output logic [DW-1:0] cur_ptr_o,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned CNT_W = DW / 2;
  localparam int unsigned TW    = $clog2(MAX_FRAME + 1);
  localparam int unsigned NB    = DW / 8;

  rx_state_e        state_q;
  logic [DW-1:0]    cur_ptr_q, dptr_q, faddr_q, fsize_q, fstat_q;
  logic [DW-1:0]    dw_q [4];
  logic [1:0]       wi_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TW-1:0]    total_q;
  logic [7:0]       byte_q;
  logic             first_q, last_q, trunc_q, done_q, err_q;

  logic [CNT_W-1:0] cap;
  logic [DW-1:0]    size_wb, stat_wb, byte_addr, lane_wdata, word_off;
  logic [NB-1:0]    lane_be;

  assign cap       = dw_q[0][DW-1:CNT_W];
  assign byte_addr = dw_q[3] + DW'(cnt_q);
  assign word_off  = DW'({wi_q, 2'b00});

  rxdma_desc_pack #(.DW(DW), .CNT_W(CNT_W)) u_pack (
    .size_i (dw_q[0]),
    .stat_i (dw_q[1]),
    .cnt_i  (cnt_q),
    .last_i (last_q),
    .first_i(first_q),
    .hdlc_i (mode_i == MODE_HDLC),
    .size_o (size_wb),
    .stat_o (stat_wb)
  );

  rxdma_byte_lane #(.DW(DW)) u_lane (
    .addr_i (byte_addr),
    .byte_i (byte_q),
    .be_o   (lane_be),
    .wdata_o(lane_wdata)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '1;
    mem_wdata_o = '0;
    rx_ready_o  = 1'b0;
    unique case (state_q)
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dptr_q + word_off;
      end
      S_WBYTE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = byte_addr;
        mem_be_o    = lane_be;
        mem_wdata_o = lane_wdata;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dptr_q + word_off;
        mem_wdata_o = wi_q[0] ? stat_wb : size_wb;
      end
      S_WBF: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = faddr_q + word_off;
        mem_wdata_o = wi_q[0] ? fstat_q : fsize_q;
      end
      S_FILL: rx_ready_o = (cnt_q != cap);
      S_DROP: rx_ready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cur_ptr_q <= '0;
      dptr_q    <= '0;
      faddr_q   <= '0;
      fsize_q   <= '0;
      fstat_q   <= '0;
      for (int i = 0; i < 4; i++) dw_q[i] <= '0;
      wi_q      <= '0;
      cnt_q     <= '0;
      total_q   <= '0;
      byte_q    <= '0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      trunc_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (ptr_wr_i) cur_ptr_q <= ptr_wdata_i;
      unique case (state_q)
        S_IDLE: if (rx_valid_i) begin
          if (cur_ptr_q == '0) begin
            err_q   <= 1'b1;
            state_q <= S_DROP;
          end else begin
            dptr_q  <= cur_ptr_q;
            faddr_q <= cur_ptr_q;
            first_q <= 1'b1;
            last_q  <= 1'b0;
            trunc_q <= 1'b0;
            wi_q    <= '0;
            cnt_q   <= '0;
            total_q <= '0;
            state_q <= S_RD;
          end
        end
        S_RD: if (mem_ack_i) begin
          dw_q[wi_q] <= mem_rdata_i;
          wi_q       <= wi_q + 2'd1;
          if (wi_q == 2'd3) state_q <= S_CHK;
        end
        S_CHK: begin
          if (!dw_q[1][OWN_BIT]) begin
            err_q   <= 1'b1;
            state_q <= S_DROP;
          end else begin
            state_q <= S_FILL;
          end
        end
        S_FILL: begin
          if (cnt_q == cap) begin
            state_q <= S_FIN;
          end else if (rx_valid_i) begin
            byte_q  <= rx_data_i;
            last_q  <= rx_last_i || (total_q == TW'(MAX_FRAME - 1));
            trunc_q <= !rx_last_i && (total_q == TW'(MAX_FRAME - 1));
            state_q <= S_WBYTE;
          end
        end
        S_WBYTE: if (mem_ack_i) begin
          cnt_q   <= cnt_q + 1'b1;
          total_q <= total_q + 1'b1;
          state_q <= last_q ? S_FIN : S_FILL;
        end
        S_FIN: begin
          wi_q <= '0;
          if (first_q) begin
            fsize_q <= size_wb;
            fstat_q <= stat_wb;
            state_q <= S_NEXT;
          end else begin
            state_q <= S_WB;
          end
        end
        S_WB: if (mem_ack_i) begin
          wi_q <= wi_q + 2'd1;
          if (wi_q[0]) state_q <= S_NEXT;
        end
        S_NEXT: begin
          wi_q <= '0;
          if (last_q) begin
            state_q <= S_WBF;
          end else if (dw_q[2] == '0) begin
            err_q   <= 1'b1;
            state_q <= S_DROP;
          end else begin
            dptr_q  <= dw_q[2];
            first_q <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_RD;
          end
        end
        S_WBF: if (mem_ack_i) begin
          wi_q <= wi_q + 2'd1;
          if (wi_q[0]) begin
            cur_ptr_q <= dw_q[2];
            done_q    <= 1'b1;
            state_q   <= trunc_q ? S_DROP : S_IDLE;
          end
        end
        S_DROP: if (rx_valid_i && rx_last_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cur_ptr_o = cur_ptr_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/rxdma_chain_chk.sv
module rxdma_chain_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ptr_wr_i,
  input logic [DW-1:0] cur_ptr_o,
  input logic          rx_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW/8-1:0] mem_be_o,
  input logic          mem_ack_i,
  input logic          done_o,
  input logic          err_o
);
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rx_ready_o); // R11
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R11
  AST_CAUSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o})); // R6
  AST_ERR_PTR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(ptr_wr_i)) |-> $stable(cur_ptr_o)); // R7
  AST_LANE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == DW/8)); // R1
endmodule

bind rxdma_chain rxdma_chain_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ptr_wr_i  (ptr_wr_i),
  .cur_ptr_o (cur_ptr_o),
  .rx_ready_o(rx_ready_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .mem_be_o  (mem_be_o),
  .mem_ack_i (mem_ack_i),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/rxdma_chain_tb.sv
module rxdma_chain_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd4;
  logic        ptr_wr = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic [31:0] cur_ptr;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        done, err;

  int checks = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0, wr_count = 0;
  logic [31:0] last_wr_addr = '0;
  logic [7:0]  mem [0:4095];

  always #5 clk = ~clk;

  rxdma_chain u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wdata), .cur_ptr_o(cur_ptr),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_last_i(rx_last), .rx_ready_o(rx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .err_o(err)
  );

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [11:0] b = {a[11:2], 2'b00};
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a[11:0] + 12'(k)] = v[8*k +: 8];
  endtask

  // memory responder and cause counters, all on the falling edge
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (err) err_cnt++;
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[{mem_addr[11:2], 2'(k)}] = mem_wdata[8*k +: 8];
        wr_count++;
        last_wr_addr = mem_addr;
      end else begin
        mem_rdata = rd32(mem_addr);
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [15:0] cap,
                          input logic [31:0] stat, input logic [31:0] nxt,
                          input logic [31:0] buf_a);
    wr32(a, {cap, 16'h0000});
    wr32(a + 4, stat);
    wr32(a + 8, nxt);
    wr32(a + 12, buf_a);
  endtask

  task automatic load_ptr(input logic [31:0] v);
    @(negedge clk);
    ptr_wr = 1'b1;
    ptr_wdata = v;
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data = seed + 8'(i);
      rx_last = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last = 1'b0;
  endtask

  task automatic wait_cause(input int d0, input int e0);
    for (int i = 0; i < 300; i++) begin
      if (done_cnt != d0 || err_cnt != e0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 reset ptr", cur_ptr, 32'h0);
    chk("R11 reset ready", {31'b0, rx_ready}, 32'h0);
    chk("R11 reset req", {31'b0, mem_req}, 32'h0);
    chk("R6 reset causes", {30'b0, done, err}, 32'h0);
  endtask

  task automatic t_ptr_write();
    load_ptr(32'h0000_0ABC);
    chk("R12 pointer load", cur_ptr, 32'h0000_0ABC);
  endtask

  task automatic t_unowned();
    int d0 = done_cnt, e0 = err_cnt;
    clear_mem();
    mode = 3'd4;
    set_desc(32'h40, 16'd4, 32'h8000_0000, 32'h50, 32'h100);
    set_desc(32'h50, 16'd4, 32'h0000_0000, 32'h60, 32'h110);
    load_ptr(32'h40);
    send_frame(7, 8'h20);
    wait_cause(d0, e0);
    chk("R7 error pulse", err_cnt - e0, 1);
    chk("R7 no done", done_cnt - d0, 0);
    chk("R7 ptr kept", cur_ptr, 32'h40);
    chk("R7 first desc not written", rd32(32'h44), 32'h8000_0000);
    chk("R7 unowned desc untouched", rd32(32'h54), 32'h0);
    chk("R1 bytes before error", rd32(32'h100), 32'h2322_2120);
  endtask

  task automatic t_single();
    int d0 = done_cnt, e0 = err_cnt;
    clear_mem();
    mode = 3'd4;
    set_desc(32'h40, 16'd16, 32'h8080_0000, 32'h80, 32'h100);
    load_ptr(32'h40);
    send_frame(5, 8'h10);
    wait_cause(d0, e0);
    chk("R6 done pulse", done_cnt - d0, 1);
    chk("R1 size word uart", rd32(32'h40), 32'h0010_0005);
    chk("R2 R3 single status", rd32(32'h44), 32'h0083_0000);
    chk("R1 data word0", rd32(32'h100), 32'h1312_1110);
    chk("R1 data word1", rd32(32'h104), 32'h0000_0014);
    chk("R6 ptr advanced", cur_ptr, 32'h80);
  endtask

  task automatic t_hdlc_chain();
    int d0 = done_cnt, e0 = err_cnt;
    clear_mem();
    mode = 3'd0;
    set_desc(32'h40, 16'd4, 32'h8000_0000, 32'h50, 32'h100);
    set_desc(32'h50, 16'd4, 32'h8000_0000, 32'h60, 32'h110);
    set_desc(32'h60, 16'd4, 32'h8000_0000, 32'h70, 32'h120);
    load_ptr(32'h40);
    send_frame(10, 8'h30);
    wait_cause(d0, e0);
    chk("R6 chain done", done_cnt - d0, 1);
    chk("R1 first count", rd32(32'h40), 32'h0004_0004);
    chk("R3 first flag", rd32(32'h44), 32'h0002_0000);
    chk("R2 middle status", rd32(32'h54), 32'h0000_0000);
    chk("R1 middle count", rd32(32'h50), 32'h0004_0004);
    chk("R5 hdlc final count", rd32(32'h60), 32'h0004_0004);
    chk("R3 last flag", rd32(32'h64), 32'h0001_0000);
    chk("R1 scattered tail", rd32(32'h120), 32'h0000_3938);
    chk("R1 middle data", rd32(32'h110), 32'h3736_3534);
    chk("R4 first status written last", last_wr_addr, 32'h44);
    chk("R6 chain ptr", cur_ptr, 32'h70);
  endtask

  task automatic t_zero_ptr();
    int d0 = done_cnt, e0 = err_cnt, w0;
    load_ptr(32'h0);
    w0 = wr_count;
    send_frame(3, 8'h55);
    wait_cause(d0, e0);
    chk("R8 zero ptr error", err_cnt - e0, 1);
    chk("R8 no memory write", wr_count - w0, 0);
    chk("R8 ptr stays zero", cur_ptr, 32'h0);
  endtask

  task automatic t_zero_next();
    int d0 = done_cnt, e0 = err_cnt;
    clear_mem();
    mode = 3'd4;
    set_desc(32'h40, 16'd2, 32'h8000_0000, 32'h0, 32'h100);
    load_ptr(32'h40);
    send_frame(3, 8'h60);
    wait_cause(d0, e0);
    chk("R9 zero link error", err_cnt - e0, 1);
    chk("R9 ptr kept", cur_ptr, 32'h40);
    chk("R9 first not returned", rd32(32'h44), 32'h8000_0000);
  endtask

  task automatic t_exact_fit();
    int d0 = done_cnt, e0 = err_cnt;
    clear_mem();
    mode = 3'd0;
    set_desc(32'h40, 16'd4, 32'h8000_0000, 32'h0, 32'h100);
    load_ptr(32'h40);
    send_frame(4, 8'h70);
    wait_cause(d0, e0);
    chk("R9 exact fit done", done_cnt - d0, 1);
    chk("R9 exact fit no error", err_cnt - e0, 0);
    chk("R5 hdlc single count", rd32(32'h40), 32'h0004_0006);
    chk("R3 first and last", rd32(32'h44), 32'h0003_0000);
    chk("R6 ptr to zero link", cur_ptr, 32'h0);
  endtask

  task automatic t_truncate();
    int d0 = done_cnt, e0 = err_cnt;
    clear_mem();
    mode = 3'd4;
    set_desc(32'h40, 16'd1024, 32'h8000_0000, 32'h50, 32'h200);
    set_desc(32'h50, 16'd1024, 32'h8000_0000, 32'h60, 32'h600);
    mem[12'hA00] = 8'h5A;
    load_ptr(32'h40);
    send_frame(2100, 8'h00);
    wait_cause(d0, e0);
    chk("R10 one done", done_cnt - d0, 1);
    chk("R10 no error", err_cnt - e0, 0);
    chk("R10 first full", rd32(32'h40), 32'h0400_0400);
    chk("R10 second full", rd32(32'h50), 32'h0400_0400);
    chk("R10 second last", rd32(32'h54), 32'h0001_0000);
    chk("R10 sentinel kept", {24'h0, mem[12'hA00]}, 32'h5A);
    chk("R10 last stored byte", {24'h0, mem[12'h9FF]}, 32'hFF);
    chk("R10 ptr advanced", cur_ptr, 32'h60);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_ptr_write();
    t_unowned();
    t_single();
    t_hdlc_chain();
    t_zero_ptr();
    t_zero_next();
    t_exact_fit();
    t_truncate();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule